// File: doc/BRIEF.md
# Index-Addressed Multi-CPU Interrupt Controller

This block collects level-sensitive interrupt lines and hands each one to a single CPU out of up to four. Software reaches it over a small register bus. A bank select sideband picks either the shared bank or a per-CPU bank, and a CPU-number sideband picks which per-CPU bank. Enable and mask state never needs a read-modify-write. Software writes the number of a source to a "set" address or a "clear" address, and the block changes only that one bit.

Each source has a small routing word that names the one CPU it is delivered to. A CPU learns which interrupt to service by reading its acknowledge register. That read returns the lowest-numbered source that is high, globally enabled, routed to that CPU and not masked by that CPU. It returns the code 1023 when no source qualifies. Source 5 is treated as a banked private source. It bypasses global enable and routing, and each CPU's own mask gates it. A per-CPU interrupt line mirrors whether that CPU's acknowledge register would return a real source.

Top module: `idx_irq_ctrl`

## Requirements
- R1: A read of shared offset 0x000 returns the number of implemented sources (32) in bits [11:2] and zero in every other bit, i.e. the value 128.
- R2: A write of value n to shared offset 0x030 sets the global enable of source n, and a write of n to shared offset 0x034 clears it. A value of n at or above the source count changes nothing.
- R3: A write of n to per-CPU offset 0x048 masks source n for the CPU named on `bus_cpu`, and a write of n to per-CPU offset 0x04C unmasks it. The masks of the other CPUs are unaffected, and n at or above the source count changes nothing.
- R4: The routing word of source n sits at shared offset 0x100 + 4n. Bit c of its low four bits delivers the source to CPU c. The word reads back in bits [3:0] with zeros above. A write whose low four bits have more than one bit set is ignored, and an all-zero value routes the source nowhere.
- R5: A read of per-CPU offset 0x044 returns in bits [9:0], with zeros above, the lowest-numbered source that is high, globally enabled, routed to the reading CPU and unmasked by it.
- R6: When no source qualifies for the reading CPU, the acknowledge read returns 1023.
- R7: Source 5 qualifies for any CPU that has it unmasked while its input is high, regardless of its global enable and its routing word.
- R8: An acknowledge read has no side effect: back-to-back reads with unchanged inputs return the same value.
- R9: After reset all global enables are clear, all per-CPU masks are set and all routing words are zero, so every acknowledge read returns 1023.
- R10: `cpu_irq[c]` is high exactly when an acknowledge read by CPU c would return a source number rather than 1023.
- R11: Read data appears on `bus_rdata` in the cycle after the read request and holds until the next read. Reads of unlisted offsets return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Register access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_percpu | input | 1 | 0 = shared bank, 1 = per-CPU bank |
| bus_cpu | input | 2 | CPU number selecting the per-CPU bank |
| bus_addr | input | 12 | Byte offset within the selected bank |
| bus_wdata | input | 32 | Write data (source number or routing word) |
| bus_rdata | output | 32 | Registered read data |
| src_lvl | input | 32 | Level-sensitive interrupt inputs |
| cpu_irq | output | 4 | Per-CPU pending indication |

## Verification
A write changes enable, mask or routing state at the clock edge that captures it, so its effect is visible on `cpu_irq` from that edge on, with no further delay. A change on `src_lvl` reaches `cpu_irq` within the same cycle, because the path is purely combinational. Read data is registered: a read presented in one cycle reflects the state of that cycle and is valid after the next rising edge. The bench therefore drives on the falling edge and samples `bus_rdata` and `cpu_irq` on the following falling edge. It compares every acknowledge value against a model that it updates write by write. This covers random mixes of enable, mask, routing and level changes, including out-of-range source numbers and illegal routing words.

// File: rtl/idx_irq_pkg.sv
package idx_irq_pkg;
  localparam int AW  = 12;
  localparam int IDW = 10;
  localparam logic [IDW-1:0] ID_NONE = 10'd1023;

  localparam logic [AW-1:0] OFS_CTRL       = 12'h000;
  localparam logic [AW-1:0] OFS_EN_SET     = 12'h030;
  localparam logic [AW-1:0] OFS_EN_CLR     = 12'h034;
  localparam logic [AW-1:0] OFS_ACK        = 12'h044;
  localparam logic [AW-1:0] OFS_MSK_SET    = 12'h048;
  localparam logic [AW-1:0] OFS_MSK_CLR    = 12'h04C;
  localparam logic [AW-1:0] OFS_ROUTE_BASE = 12'h100;

  typedef enum logic [2:0] {
    OP_IDLE, OP_EN_SET, OP_EN_CLR, OP_MSK_SET, OP_MSK_CLR, OP_ROUTE
  } wr_op_e;

  // shared control word: source count in [11:2]
  function automatic logic [31:0] ctrl_word(int unsigned nsrc);
    return 32'(nsrc) << 2;
  endfunction
endpackage

// File: rtl/iic_src_regs.sv
module iic_src_regs #(
  parameter int NSRC = 32,
  parameter int NCPU = 4,
  parameter int SW   = 5
)(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       en_set,
  input  logic                       en_clr,
  input  logic [SW-1:0]              idx,
  input  logic                       route_we,
  input  logic [SW-1:0]              route_sel,
  input  logic [NCPU-1:0]            route_val,
  output logic [NSRC-1:0]            gen_en,
  output logic [NSRC-1:0][NCPU-1:0]  route_q
);
  // zero or one bit set
  function automatic logic route_legal(logic [NCPU-1:0] v);
    return (v & (v - NCPU'(1))) == '0;
  endfunction

  logic route_ok;
  assign route_ok = route_we && route_legal(route_val);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gen_en  <= '0;
      route_q <= '0;
    end else begin
      if (en_set) gen_en[idx] <= 1'b1;
      if (en_clr) gen_en[idx] <= 1'b0;
      if (route_ok) route_q[route_sel] <= route_val;
    end
  end
endmodule

// File: rtl/iic_pick.sv
module iic_pick import idx_irq_pkg::*; #(
  parameter int NSRC = 32
)(
  input  logic [NSRC-1:0] elig,
  output logic [IDW-1:0]  id,
  output logic            any
);
  function automatic logic [IDW-1:0] lowest_id(logic [NSRC-1:0] v);
    logic [IDW-1:0] r;
    r = ID_NONE;
    for (int n = NSRC - 1; n >= 0; n--)
      if (v[n]) r = IDW'(n);
    return r;
  endfunction

  assign id  = lowest_id(elig);
  assign any = |elig;
endmodule

// File: rtl/iic_cpu_port.sv
module iic_cpu_port import idx_irq_pkg::*; #(
  parameter int NSRC     = 32,
  parameter int SW       = 5,
  parameter int PRIV_SRC = 5
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            msk_set,
  input  logic            msk_clr,
  input  logic [SW-1:0]   idx,
  input  logic [NSRC-1:0] src_lvl,
  input  logic [NSRC-1:0] gen_en,
  input  logic [NSRC-1:0] route_col,
  output logic [NSRC-1:0] mask_q,
  output logic [IDW-1:0]  ack_id,
  output logic            irq
);
  logic [NSRC-1:0] elig;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '1;
    end else begin
      if (msk_set) mask_q[idx] <= 1'b1;
      if (msk_clr) mask_q[idx] <= 1'b0;
    end
  end

  for (genvar n = 0; n < NSRC; n++) begin : g_elig
    localparam logic IS_PRIV = (n == PRIV_SRC);
    assign elig[n] = src_lvl[n] & ~mask_q[n] & (IS_PRIV | (gen_en[n] & route_col[n]));
  end

  iic_pick #(.NSRC(NSRC)) u_pick (
    .elig (elig),
    .id   (ack_id),
    .any  (irq)
  );
endmodule

// File: rtl/idx_irq_ctrl.sv
module idx_irq_ctrl import idx_irq_pkg::*; #(
  parameter int NSRC     = 32,
  parameter int NCPU     = 4,
  parameter int PRIV_SRC = 5
)(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_valid,
  input  logic                     bus_write,
  input  logic                     bus_percpu,
  input  logic [$clog2(NCPU)-1:0]  bus_cpu,
  input  logic [AW-1:0]            bus_addr,
  input  logic [31:0]              bus_wdata,
  output logic [31:0]              bus_rdata,
  input  logic [NSRC-1:0]          src_lvl,
  output logic [NCPU-1:0]          cpu_irq
);
  localparam int SW   = $clog2(NSRC);
  localparam int CPUW = $clog2(NCPU);

  logic rd_req, wr_req;
  wr_op_e wr_op;
  logic idx_ok;
  logic [SW-1:0] wr_idx;
  logic [AW-1:0] route_off;
  logic route_win;
  logic [SW-1:0] route_sel;
  logic en_set_hit, en_clr_hit, route_hit;
  logic [NCPU-1:0] cpu_sel, msk_set_vec, msk_clr_vec;
  logic [NSRC-1:0] gen_en;
  logic [NSRC-1:0][NCPU-1:0] route_q;
  logic [NCPU-1:0][NSRC-1:0] route_col;
  logic [NCPU-1:0][NSRC-1:0] mask_q;
  logic [NCPU-1:0][IDW-1:0] ack_id;
  logic [31:0] rd_val, rdata_q;

  assign rd_req = bus_valid & ~bus_write;
  assign wr_req = bus_valid & bus_write;

  assign idx_ok = bus_wdata < 32'(NSRC);
  assign wr_idx = bus_wdata[SW-1:0];

  assign route_off = bus_addr - OFS_ROUTE_BASE;
  assign route_win = (bus_addr >= OFS_ROUTE_BASE) &&
                     (32'(route_off[AW-1:2]) < 32'(NSRC)) &&
                     (route_off[1:0] == 2'b00);
  assign route_sel = route_off[SW+1:2];

  always_comb begin
    wr_op = OP_IDLE;
    if (wr_req) begin
      if (!bus_percpu) begin
        if (bus_addr == OFS_EN_SET)      wr_op = OP_EN_SET;
        else if (bus_addr == OFS_EN_CLR) wr_op = OP_EN_CLR;
        else if (route_win)              wr_op = OP_ROUTE;
      end else begin
        if (bus_addr == OFS_MSK_SET)      wr_op = OP_MSK_SET;
        else if (bus_addr == OFS_MSK_CLR) wr_op = OP_MSK_CLR;
      end
    end
  end

  assign en_set_hit = (wr_op == OP_EN_SET) && idx_ok;
  assign en_clr_hit = (wr_op == OP_EN_CLR) && idx_ok;
  assign route_hit  = (wr_op == OP_ROUTE);

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    assign cpu_sel[c]     = (bus_cpu == CPUW'(c));
    assign msk_set_vec[c] = (wr_op == OP_MSK_SET) && idx_ok && cpu_sel[c];
    assign msk_clr_vec[c] = (wr_op == OP_MSK_CLR) && idx_ok && cpu_sel[c];

    for (genvar n = 0; n < NSRC; n++) begin : g_col
      assign route_col[c][n] = route_q[n][c];
    end

    iic_cpu_port #(.NSRC(NSRC), .SW(SW), .PRIV_SRC(PRIV_SRC)) u_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .msk_set   (msk_set_vec[c]),
      .msk_clr   (msk_clr_vec[c]),
      .idx       (wr_idx),
      .src_lvl   (src_lvl),
      .gen_en    (gen_en),
      .route_col (route_col[c]),
      .mask_q    (mask_q[c]),
      .ack_id    (ack_id[c]),
      .irq       (cpu_irq[c])
    );
  end

  iic_src_regs #(.NSRC(NSRC), .NCPU(NCPU), .SW(SW)) u_src (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_set    (en_set_hit),
    .en_clr    (en_clr_hit),
    .idx       (wr_idx),
    .route_we  (route_hit),
    .route_sel (route_sel),
    .route_val (bus_wdata[NCPU-1:0]),
    .gen_en    (gen_en),
    .route_q   (route_q)
  );

  always_comb begin
    rd_val = '0;
    if (!bus_percpu) begin
      if (bus_addr == OFS_CTRL) rd_val = ctrl_word(NSRC);
      else if (route_win)       rd_val = 32'(route_q[route_sel]);
    end else if (bus_addr == OFS_ACK) begin
      for (int c = 0; c < NCPU; c++)
        if (cpu_sel[c]) rd_val = 32'(ack_id[c]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      rdata_q <= '0;
    else if (rd_req) rdata_q <= rd_val;
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/idx_irq_ctrl_chk.sv
module idx_irq_ctrl_chk #(
  parameter int NSRC = 32,
  parameter int NCPU = 4,
  parameter int SW   = 5
)(
  input logic                      clk,
  input logic                      rst_n,
  input logic                      bus_valid,
  input logic                      bus_write,
  input logic [31:0]               bus_rdata,
  input logic [NSRC-1:0]           src_lvl,
  input logic [NSRC-1:0]           gen_en,
  input logic [NCPU-1:0][NSRC-1:0] mask_q,
  input logic [NSRC-1:0][NCPU-1:0] route_q,
  input logic [NCPU-1:0][9:0]      ack_id,
  input logic [NCPU-1:0]           cpu_irq,
  input logic                      en_set_hit,
  input logic                      en_clr_hit,
  input logic [SW-1:0]             wr_idx,
  input logic [NCPU-1:0]           msk_set_vec,
  input logic [NCPU-1:0]           msk_clr_vec
);
  // R2
  en_set_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_set_hit |=> gen_en[$past(wr_idx)]);
  // R2
  en_clr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_clr_hit |=> !gen_en[$past(wr_idx)]);
  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && !bus_write) |=> $stable(bus_rdata));

  for (genvar c = 0; c < NCPU; c++) begin : g_c
    // R3
    mask_set_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      msk_set_vec[c] |=> mask_q[c][$past(wr_idx)]);
    // R3
    mask_clr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      msk_clr_vec[c] |=> !mask_q[c][$past(wr_idx)]);
    // R10
    irq_matches_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_irq[c] == (ack_id[c] != 10'd1023));
    // R5
    ack_is_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_id[c] != 10'd1023) |->
        (32'(ack_id[c]) < 32'(NSRC)) && src_lvl[ack_id[c][SW-1:0]] && !mask_q[c][ack_id[c][SW-1:0]]);
  end

  for (genvar n = 0; n < NSRC; n++) begin : g_n
    // R4
    route_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(route_q[n]));
  end
endmodule

bind idx_irq_ctrl idx_irq_ctrl_chk #(.NSRC(NSRC), .NCPU(NCPU), .SW(SW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_valid   (bus_valid),
  .bus_write   (bus_write),
  .bus_rdata   (bus_rdata),
  .src_lvl     (src_lvl),
  .gen_en      (gen_en),
  .mask_q      (mask_q),
  .route_q     (route_q),
  .ack_id      (ack_id),
  .cpu_irq     (cpu_irq),
  .en_set_hit  (en_set_hit),
  .en_clr_hit  (en_clr_hit),
  .wr_idx      (wr_idx),
  .msk_set_vec (msk_set_vec),
  .msk_clr_vec (msk_clr_vec)
);

// File: tb/idx_irq_ctrl_bench.sv
module idx_irq_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 32;
  localparam int NCPU = 4;
  localparam int PRIV = 5;
  localparam int NONE = 1023;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0, bus_percpu = 1'b0;
  logic [1:0] bus_cpu = '0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NSRC-1:0] src_lvl = '0;
  logic [NCPU-1:0] cpu_irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  bit [NSRC-1:0] m_en;
  bit [NSRC-1:0] m_msk [NCPU];
  bit [NCPU-1:0] m_rt  [NSRC];

  always #(CLK_PERIOD/2) clk = ~clk;

  idx_irq_ctrl u_idx_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_percpu(bus_percpu), .bus_cpu(bus_cpu), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_lvl(src_lvl), .cpu_irq(cpu_irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model_ack(int c);
    for (int n = 0; n < NSRC; n++)
      if (src_lvl[n] && !m_msk[c][n] && (n == PRIV || (m_en[n] && m_rt[n][c])))
        return n;
    return NONE;
  endfunction

  function automatic void model_wr(bit pc, int cpu, int addr, int data);
    bit [3:0] v;
    if (!pc) begin
      if (addr == 'h30 && data >= 0 && data < NSRC) m_en[data] = 1'b1;
      if (addr == 'h34 && data >= 0 && data < NSRC) m_en[data] = 1'b0;
      if (addr >= 'h100 && addr < 'h100 + 4*NSRC && addr % 4 == 0) begin
        v = data[3:0];
        if ((v & (v - 4'd1)) == 4'd0) m_rt[(addr - 'h100) / 4] = v;
      end
    end else begin
      if (addr == 'h48 && data >= 0 && data < NSRC) m_msk[cpu][data] = 1'b1;
      if (addr == 'h4C && data >= 0 && data < NSRC) m_msk[cpu][data] = 1'b0;
    end
  endfunction

  task automatic bus_wr(input bit pc, input int cpu, input int addr, input int data);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_percpu = pc;
    bus_cpu = 2'(cpu); bus_addr = 12'(addr); bus_wdata = data;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    model_wr(pc, cpu, addr, data);
  endtask

  task automatic bus_rd(input bit pc, input int cpu, input int addr, output int data);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_percpu = pc;
    bus_cpu = 2'(cpu); bus_addr = 12'(addr);
    @(negedge clk);
    data = bus_rdata;
    bus_valid = 1'b0;
  endtask

  task automatic check_acks(input string req);
    int d;
    for (int c = 0; c < NCPU; c++) begin
      bus_rd(1'b1, c, 'h44, d);
      chk(req, d, model_ack(c));
      chk("R10", int'(cpu_irq[c]), int'(model_ack(c) != NONE));
    end
  endtask

  initial begin
    int d, d2;
    void'($urandom(32'd20240611));
    m_en = '0;
    for (int c = 0; c < NCPU; c++) m_msk[c] = '1;
    for (int n = 0; n < NSRC; n++) m_rt[n] = '0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    src_lvl = '1;

    // R9: reset state, all sources high but nothing qualifies
    for (int c = 0; c < NCPU; c++) begin
      bus_rd(1'b1, c, 'h44, d);
      chk("R9", d, NONE);
      chk("R9", int'(cpu_irq[c]), 0);
    end
    bus_rd(1'b0, 0, 'h10C, d);
    chk("R9", d, 0);

    // R1
    bus_rd(1'b0, 0, 'h000, d);
    chk("R1", d, 128);
    // R11: unlisted offset
    bus_rd(1'b0, 0, 'h008, d);
    chk("R11", d, 0);

    // R5: route src 3 to CPU0, enable, unmask on CPU0
    bus_wr(1'b0, 0, 'h10C, 1);
    bus_wr(1'b0, 0, 'h30, 3);
    bus_wr(1'b1, 0, 'h4C, 3);
    bus_rd(1'b1, 0, 'h44, d);
    chk("R5", d, 3);
    chk("R10", int'(cpu_irq), 1);
    bus_rd(1'b1, 1, 'h44, d);
    chk("R6", d, NONE);

    // R4: illegal routing word ignored, readback
    bus_wr(1'b0, 0, 'h10C, 3);
    bus_rd(1'b0, 0, 'h10C, d);
    chk("R4", d, 1);
    bus_wr(1'b0, 0, 'h10C, 32'hFFFF_FFF4);
    bus_rd(1'b0, 0, 'h10C, d);
    chk("R4", d, 4);
    bus_wr(1'b0, 0, 'h10C, 1);

    // R3: mask from CPU1 leaves CPU0 alone
    bus_wr(1'b1, 1, 'h48, 3);
    bus_rd(1'b1, 0, 'h44, d);
    chk("R3", d, 3);
    bus_wr(1'b1, 0, 'h48, 3);
    bus_rd(1'b1, 0, 'h44, d);
    chk("R3", d, NONE);
    bus_wr(1'b1, 0, 'h4C, 3);

    // R2: out-of-range index ignored, clear works
    bus_wr(1'b0, 0, 'h34, 35);
    bus_rd(1'b1, 0, 'h44, d);
    chk("R2", d, 3);
    bus_wr(1'b0, 0, 'h34, 3);
    bus_rd(1'b1, 0, 'h44, d);
    chk("R2", d, NONE);
    bus_wr(1'b0, 0, 'h30, 3);

    // R7: private source ignores enable and routing
    bus_wr(1'b1, 2, 'h4C, PRIV);
    bus_rd(1'b1, 2, 'h44, d);
    chk("R7", d, PRIV);
    bus_rd(1'b1, 3, 'h44, d);
    chk("R7", d, NONE);
    @(negedge clk); src_lvl[PRIV] = 1'b0;
    bus_rd(1'b1, 2, 'h44, d);
    chk("R7", d, NONE);
    src_lvl = '1;

    // R8: repeated reads, R11 hold
    bus_rd(1'b1, 0, 'h44, d);
    bus_rd(1'b1, 0, 'h44, d2);
    chk("R8", d2, d);
    chk("R8", d, 3);
    repeat (3) @(negedge clk);
    chk("R11", bus_rdata, d);

    // random mix
    for (int it = 0; it < 250; it++) begin
      int op, idx, cpu;
      op  = $urandom % 6;
      idx = $urandom % 40;
      cpu = $urandom % NCPU;
      case (op)
        0: bus_wr(1'b0, 0, 'h30, idx);
        1: bus_wr(1'b0, 0, 'h34, idx);
        2: bus_wr(1'b1, cpu, 'h48, idx);
        3: bus_wr(1'b1, cpu, 'h4C, idx);
        4: bus_wr(1'b0, 0, 'h100 + 4 * (idx % NSRC), $urandom % 16);
        default: begin @(negedge clk); src_lvl = $urandom | $urandom; end
      endcase
      check_acks("R5");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule